// File: doc/BRIEF.md
# Saturating Add/Subtract Execute Unit

This block is the execute stage for a group of signed 32-bit clamping arithmetic operations. Each issue presents one instruction (a 16-bit first word and, for the long form, a 16-bit extension word) together with the values of the two source registers named by that instruction. The unit decodes the operation and forms the result. When the true result falls outside the signed 32-bit range, the unit clamps it to the nearest bound. It presents the result with a write strobe and the destination index for the register file.

Five operations are recognised: add two registers, add a sign-extended 5-bit constant, subtract one register from the other, the same subtraction with the operands swapped, and a three-operand subtract of a sign-extended 16-bit constant. Every recognised operation updates five condition bits: carry/borrow, overflow, sign, zero, and a sticky saturation bit. The sticky bit records that some clamp has happened since reset.

Operands are sampled on the clock edge where `issue_valid` is high. The write-back outputs and condition bits change on that same edge, so they are visible one cycle after issue. Register file storage, fetch and hazard handling belong to the neighbouring stages.

Top module: `sat_exec_unit`

## Requirements
- R1: After a synchronous active-low reset, `wb_en`, `wb_idx`, `wb_data` and all five condition bits are zero.
- R2: The first word is decoded as destination index in bits 15:11, operation code in bits 10:5 and source field (register or 5-bit constant) in bits 4:0. `wb_idx` equals bits 15:11. An issue whose code is not 000110, 010001, 000101, 000100 or 110011 leaves `wb_en` low and leaves `wb_data` and every condition bit unchanged.
- R3: Code 000110 yields clamp(rs2_val + rs1_val).
- R4: Code 010001 yields clamp(rs2_val + sign-extended bits 4:0 of the first word).
- R5: Code 000101 yields clamp(rs2_val − rs1_val).
- R6: Code 000100 yields clamp(rs1_val − rs2_val).
- R7: Code 110011 yields clamp(rs1_val − sign-extended `insn_hi`), and `rs2_val` has no effect on it.
- R8: A result above 0x7FFFFFFF is replaced by 0x7FFFFFFF, and a result below −2^31 is replaced by 0x80000000.
- R9: `flag_ov` is 1 exactly when a clamp occurred. `flag_s` is bit 31 and `flag_z` is the zero test of the clamped result.
- R10: `flag_cy` is the unsigned carry out of an add, or the unsigned borrow (minuend below subtrahend) of a subtract, taken before any clamp.
- R11: `flag_sat` is set by any clamping operation and stays set through later non-clamping operations until reset.
- R12: The result, strobe and condition bits appear on the edge that samples the issue. `wb_en` is high for exactly that one cycle per issue, and a cycle without an issue leaves `wb_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| insn_lo | input | 16 | First instruction word |
| insn_hi | input | 16 | Extension word (16-bit constant) |
| rs1_val | input | 32 | Value of the register named in bits 4:0 |
| rs2_val | input | 32 | Value of the register named in bits 15:11 |
| wb_en | output | 1 | Write strobe for the destination register |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 32 | Clamped result |
| flag_cy | output | 1 | Carry/borrow of the unclamped operation |
| flag_ov | output | 1 | Clamp occurred |
| flag_s | output | 1 | Sign of result |
| flag_z | output | 1 | Result is zero |
| flag_sat | output | 1 | Sticky saturation |

## Verification
Some internal faults would corrupt only the stored state, such as a swapped operand order, a wrong sign extension or a clamp toward the wrong bound. Each of these shows on `wb_data` and the condition bits in the cycle right after the offending issue. The vector set therefore pairs every operation with cases that clamp high, clamp low, wrap through zero and do neither. A sticky bit that clears too early only shows on a later, non-clamping issue, so the bench runs such an issue after a clamp. A decoder that accepts an unknown code shows as a stray `wb_en` pulse or a changed flag one cycle later.

// File: rtl/sat_exec_pkg.sv
// Package: shared widths, operation codes and flag record for the
// saturating execute unit. Assumes a 32-bit datapath and 16-bit words.
package sat_exec_pkg;
    localparam int XLEN     = 32;
    localparam int HW_W     = 16;
    localparam int IDX_W    = 5;
    localparam int OPC_W    = 6;
    localparam int SIMM_W   = 5;

    localparam logic [OPC_W-1:0] OPC_ADD  = 6'b000110;
    localparam logic [OPC_W-1:0] OPC_ADDI = 6'b010001;
    localparam logic [OPC_W-1:0] OPC_SUB  = 6'b000101;
    localparam logic [OPC_W-1:0] OPC_SUBR = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_SUBI = 6'b110011;

    typedef enum logic [2:0] {
        K_NONE, K_ADD, K_ADDI, K_SUB, K_SUBR, K_SUBI
    } op_kind_t;

    typedef struct packed {
        logic cy;
        logic ov;
        logic s;
        logic z;
        logic sat;
    } cond_t;
endpackage

// File: rtl/sat_exec_decode.sv
// Decoder: splits the first word into fields, picks the operation kind and
// routes the minuend/addend pair. Assumes insn_hi is only meaningful for
// the long-constant subtract; all other kinds ignore it.
module sat_exec_decode
    import sat_exec_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [HW_W-1:0]  insn_lo,
    input  logic [HW_W-1:0]  insn_hi,
    input  logic [W-1:0]     rs1_val,
    input  logic [W-1:0]     rs2_val,
    output logic             legal,
    output logic             is_sub,
    output logic [IDX_W-1:0] dest,
    output logic [W-1:0]     opx,
    output logic [W-1:0]     opy
);
    localparam int OPC_LSB = SIMM_W;
    localparam int IDX_LSB = SIMM_W + OPC_W;

    op_kind_t          kind;
    logic [OPC_W-1:0]  opc;
    logic [SIMM_W-1:0] fld;
    logic [W-1:0]      simm_ext;
    logic [W-1:0]      limm_ext;

    assign opc      = insn_lo[OPC_LSB +: OPC_W];
    assign fld      = insn_lo[SIMM_W-1:0];
    assign dest     = insn_lo[IDX_LSB +: IDX_W];
    assign simm_ext = {{(W-SIMM_W){fld[SIMM_W-1]}}, fld};
    assign limm_ext = {{(W-HW_W){insn_hi[HW_W-1]}}, insn_hi};

    // Map the operation code to a kind.
    always_comb begin
        unique case (opc)
            OPC_ADD:  kind = K_ADD;
            OPC_ADDI: kind = K_ADDI;
            OPC_SUB:  kind = K_SUB;
            OPC_SUBR: kind = K_SUBR;
            OPC_SUBI: kind = K_SUBI;
            default:  kind = K_NONE;
        endcase
    end

    // Route operands and direction for the chosen kind.
    always_comb begin
        legal  = 1'b1;
        is_sub = 1'b0;
        opx    = rs2_val;
        opy    = rs1_val;
        case (kind)
            K_ADD:  ;
            K_ADDI: opy = simm_ext;
            K_SUB:  is_sub = 1'b1;
            K_SUBR: begin is_sub = 1'b1; opx = rs1_val; opy = rs2_val; end
            K_SUBI: begin is_sub = 1'b1; opx = rs1_val; opy = limm_ext; end
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/sat_exec_arith.sv
// Arithmetic core: forms x+y or x-y, the unsigned carry/borrow, detects
// signed overflow and clamps toward the bound on the side of x's sign.
// Assumes two's complement operands of width W.
module sat_exec_arith #(
    parameter int W = 32
) (
    input  logic         is_sub,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] res,
    output logic         cy,
    output logic         ov
);
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] y_eff;
    logic [W:0]   wide;
    logic [W-1:0] raw;

    // Unclamped sum, with subtract done as x + ~y + 1.
    always_comb begin
        y_eff = is_sub ? ~y : y;
        wide  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, is_sub};
        raw   = wide[W-1:0];
    end

    // Overflow test, carry/borrow and clamp selection.
    always_comb begin
        ov  = (x[W-1] == y_eff[W-1]) && (raw[W-1] != x[W-1]);
        cy  = is_sub ? ~wide[W] : wide[W];
        res = ov ? (x[W-1] ? NEG_MIN : POS_MAX) : raw;
    end
endmodule

// File: rtl/sat_exec_unit.sv
// Top: decode + arithmetic + write-back/condition registers. Results are
// registered on the edge that samples issue_valid. The sticky bit is only
// cleared by reset. Assumes the caller supplies register values matching
// the fields of insn_lo.
module sat_exec_unit
    import sat_exec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [HW_W-1:0]   insn_lo,
    input  logic [HW_W-1:0]   insn_hi,
    input  logic [XLEN-1:0]   rs1_val,
    input  logic [XLEN-1:0]   rs2_val,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [XLEN-1:0]   wb_data,
    output logic              flag_cy,
    output logic              flag_ov,
    output logic              flag_s,
    output logic              flag_z,
    output logic              flag_sat
);
    logic             legal;
    logic             is_sub;
    logic [IDX_W-1:0] dest;
    logic [XLEN-1:0]  opx;
    logic [XLEN-1:0]  opy;
    logic [XLEN-1:0]  res;
    logic             cy_n;
    logic             ov_n;
    logic             fire;
    cond_t            cond_q;

    sat_exec_decode #(.W(XLEN)) u_dec (
        .insn_lo (insn_lo),
        .insn_hi (insn_hi),
        .rs1_val (rs1_val),
        .rs2_val (rs2_val),
        .legal   (legal),
        .is_sub  (is_sub),
        .dest    (dest),
        .opx     (opx),
        .opy     (opy)
    );

    sat_exec_arith #(.W(XLEN)) u_alu (
        .is_sub (is_sub),
        .x      (opx),
        .y      (opy),
        .res    (res),
        .cy     (cy_n),
        .ov     (ov_n)
    );

    assign fire = issue_valid && legal;

    // Write-back strobe: one cycle per accepted issue.
    always_ff @(posedge clk) begin
        if (!rst_n) wb_en <= 1'b0;
        else        wb_en <= fire;
    end

    // Result and destination hold until the next accepted issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_idx  <= '0;
            wb_data <= '0;
        end else if (fire) begin
            wb_idx  <= dest;
            wb_data <= res;
        end
    end

    // Condition bits; saturation bit accumulates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q <= '0;
        end else if (fire) begin
            cond_q.cy  <= cy_n;
            cond_q.ov  <= ov_n;
            cond_q.s   <= res[XLEN-1];
            cond_q.z   <= (res == '0);
            cond_q.sat <= cond_q.sat | ov_n;
        end
    end

    assign flag_cy  = cond_q.cy;
    assign flag_ov  = cond_q.ov;
    assign flag_s   = cond_q.s;
    assign flag_z   = cond_q.z;
    assign flag_sat = cond_q.sat;
endmodule

// File: rtl/sat_exec_unit_chk.sv
// Checker: temporal properties on the ports of sat_exec_unit, bound below.
module sat_exec_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        issue_valid,
    input logic [15:0] insn_lo,
    input logic        wb_en,
    input logic [31:0] wb_data,
    input logic        flag_ov,
    input logic        flag_s,
    input logic        flag_z,
    input logic        flag_sat
);
    logic [5:0] opc;
    logic       known;
    assign opc   = insn_lo[10:5];
    assign known = (opc == 6'b000110) || (opc == 6'b010001) ||
                   (opc == 6'b000101) || (opc == 6'b000100) ||
                   (opc == 6'b110011);

    // R11: once set, the sticky bit stays set.
    a_r11_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_sat |=> flag_sat);

    // R8: a clamp leaves one of the two bounds on the result.
    a_r8_clamp_bound: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ov |-> (wb_data == 32'h7FFF_FFFF || wb_data == 32'h8000_0000));

    // R9: sign and zero bits agree with a freshly written result.
    a_r9_s_z_match: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (flag_s == wb_data[31]) && (flag_z == (wb_data == 32'h0)));

    // R11: an overflow always leaves the sticky bit set.
    a_r11_ov_sets_sat: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ov |-> flag_sat);

    // R2: an unknown code produces no write.
    a_r2_unknown_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !known) |=> !wb_en);

    // R12: no issue, no write and no change of result.
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> (!wb_en && $stable(wb_data)));
endmodule

bind sat_exec_unit sat_exec_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .insn_lo     (insn_lo),
    .wb_en       (wb_en),
    .wb_data     (wb_data),
    .flag_ov     (flag_ov),
    .flag_s      (flag_s),
    .flag_z      (flag_z),
    .flag_sat    (flag_sat)
);

// File: tb/sat_exec_unit_bench.sv
`timescale 1ns/1ps
module sat_exec_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [15:0] insn_lo = '0;
    logic [15:0] insn_hi = '0;
    logic [31:0] rs1_val = '0;
    logic [31:0] rs2_val = '0;
    logic        wb_en;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data;
    logic        flag_cy, flag_ov, flag_s, flag_z, flag_sat;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sat_exec_unit u_sat_exec_unit (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .insn_lo(insn_lo), .insn_hi(insn_hi),
        .rs1_val(rs1_val), .rs2_val(rs2_val),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .flag_cy(flag_cy), .flag_ov(flag_ov), .flag_s(flag_s),
        .flag_z(flag_z), .flag_sat(flag_sat)
    );

    localparam logic [5:0] ADD  = 6'b000110;
    localparam logic [5:0] ADDI = 6'b010001;
    localparam logic [5:0] SUB  = 6'b000101;
    localparam logic [5:0] SUBR = 6'b000100;
    localparam logic [5:0] SUBI = 6'b110011;

    // {insn_lo, insn_hi, rs1, rs2, expected data, expected {cy,ov,s,z}}
    localparam int NV = 17;
    localparam logic [131:0] VEC [NV] = '{
        {{5'd2,  ADD,  5'd1},     16'h0,    32'd3,         32'd5,         32'd8,         4'b0000},
        {{5'd3,  ADD,  5'd4},     16'h0,    32'h1,         32'h7FFF_FFFF, 32'h7FFF_FFFF, 4'b0100},
        {{5'd4,  ADD,  5'd5},     16'h0,    32'h1,         32'hFFFF_FFFF, 32'h0,         4'b1001},
        {{5'd5,  ADD,  5'd6},     16'h0,    32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 4'b1110},
        {{5'd6,  ADDI, 5'b11111}, 16'h0,    32'h0,         32'd10,        32'd9,         4'b1000},
        {{5'd7,  ADDI, 5'd15},    16'h0,    32'h0,         32'h7FFF_FFFE, 32'h7FFF_FFFF, 4'b0100},
        {{5'd8,  ADDI, 5'b10000}, 16'h0,    32'h0,         32'h8000_0000, 32'h8000_0000, 4'b1110},
        {{5'd9,  SUB,  5'd1},     16'h0,    32'd5,         32'd3,         32'hFFFF_FFFE, 4'b1010},
        {{5'd10, SUB,  5'd2},     16'h0,    32'h1,         32'h8000_0000, 32'h8000_0000, 4'b0110},
        {{5'd11, SUB,  5'd3},     16'h0,    32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 4'b1100},
        {{5'd12, SUB,  5'd4},     16'h0,    32'd1234,      32'd1234,      32'h0,         4'b0001},
        {{5'd13, SUBR, 5'd5},     16'h0,    32'd3,         32'd5,         32'hFFFF_FFFE, 4'b1010},
        {{5'd14, SUBR, 5'd6},     16'h0,    32'h8000_0000, 32'h1,         32'h8000_0000, 4'b0110},
        {{5'd15, SUBI, 5'd7},     16'h0064, 32'd100,       32'hDEAD_BEEF, 32'h0,         4'b0001},
        {{5'd16, SUBI, 5'd8},     16'hFFFF, 32'd5,         32'hDEAD_BEEF, 32'd6,         4'b1000},
        {{5'd17, SUBI, 5'd9},     16'h8000, 32'h7FFF_FFF0, 32'h1234_5678, 32'h7FFF_FFFF, 4'b1100},
        {{5'd18, SUBI, 5'd10},    16'h7FFF, 32'h8000_0010, 32'h0,         32'h8000_0000, 4'b0110}
    };

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One issue; returns at the next falling edge with outputs settled.
    task automatic issue(input logic [15:0] lo, input logic [15:0] hi,
                         input logic [31:0] r1, input logic [31:0] r2,
                         input bit v);
        @(negedge clk);
        insn_lo = lo; insn_hi = hi; rs1_val = r1; rs2_val = r2;
        issue_valid = v;
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    function automatic string op_tag(input logic [5:0] opc);
        case (opc)
            ADD:     return "R3";
            ADDI:    return "R4";
            SUB:     return "R5";
            SUBR:    return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin : main
        logic [31:0] keep;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(wb_en == 1'b0 && wb_idx == '0, "R1 strobe/index", {27'd0, wb_idx}, 32'h0);
        check(wb_data == 32'h0, "R1 data", wb_data, 32'h0);
        check({flag_cy, flag_ov, flag_s, flag_z, flag_sat} == 5'b0, "R1 flags",
              {27'd0, flag_cy, flag_ov, flag_s, flag_z, flag_sat}, 32'h0);
        rst_n = 1'b1;

        // R11: sticky bit stays clear without a clamp
        issue({5'd1, ADD, 5'd2}, 16'h0, 32'd1, 32'd1, 1'b1);
        check(flag_sat == 1'b0, "R11 sat clear before clamp", {31'd0, flag_sat}, 32'h0);

        // Table walk: every operation kind, clamp and carry cases
        for (int i = 0; i < NV; i++) begin
            logic [15:0] lo;
            logic [31:0] exp_d;
            logic [3:0]  exp_f;
            lo    = VEC[i][131:116];
            exp_d = VEC[i][35:4];
            exp_f = VEC[i][3:0];
            issue(lo, VEC[i][115:100], VEC[i][99:68], VEC[i][67:36], 1'b1);
            check(wb_en == 1'b1, "R12 strobe after issue", {31'd0, wb_en}, 32'h1);
            check(wb_idx == lo[15:11], "R2 destination", {27'd0, wb_idx}, {27'd0, lo[15:11]});
            check(wb_data == exp_d, {op_tag(lo[10:5]), " R8 result"}, wb_data, exp_d);
            check(flag_cy == exp_f[3], "R10 carry/borrow", {31'd0, flag_cy}, {31'd0, exp_f[3]});
            check({flag_ov, flag_s, flag_z} == exp_f[2:0], "R9 ov/s/z",
                  {29'd0, flag_ov, flag_s, flag_z}, {29'd0, exp_f[2:0]});
            @(negedge clk);
            check(wb_en == 1'b0, "R12 single-cycle strobe", {31'd0, wb_en}, 32'h0);
        end

        // R11: clamp happened above; a clean op leaves it set with ov low
        issue({5'd20, ADD, 5'd1}, 16'h0, 32'd2, 32'd2, 1'b1);
        check(flag_sat == 1'b1 && flag_ov == 1'b0, "R11 sat sticky",
              {30'd0, flag_sat, flag_ov}, 32'h2);

        // R7: rs2 value has no effect on the long-constant subtract
        issue({5'd21, SUBI, 5'd1}, 16'h0010, 32'd48, 32'hFFFF_FFFF, 1'b1);
        check(wb_data == 32'd32, "R7 rs2 ignored (a)", wb_data, 32'd32);
        issue({5'd21, SUBI, 5'd1}, 16'h0010, 32'd48, 32'h0, 1'b1);
        check(wb_data == 32'd32, "R7 rs2 ignored (b)", wb_data, 32'd32);

        // R2: unknown codes write nothing and disturb nothing
        keep = wb_data;
        issue({5'd22, 6'b111111, 5'd1}, 16'h0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1);
        check(wb_en == 1'b0, "R2 unknown code strobe", {31'd0, wb_en}, 32'h0);
        check(wb_data == keep && wb_idx == 5'd21, "R2 unknown code data", wb_data, keep);
        check({flag_cy, flag_ov, flag_s, flag_z, flag_sat} == 5'b00001, "R2 unknown code flags",
              {27'd0, flag_cy, flag_ov, flag_s, flag_z, flag_sat}, 32'h1);
        issue({5'd23, 6'b000000, 5'd1}, 16'h0, 32'd1, 32'd1, 1'b1);
        check(wb_en == 1'b0 && wb_data == keep, "R2 zero code ignored", wb_data, keep);

        // R12: valid low with a legal code does nothing
        issue({5'd24, ADD, 5'd1}, 16'h0, 32'd7, 32'd7, 1'b0);
        check(wb_en == 1'b0 && wb_data == keep, "R12 no issue no write", wb_data, keep);

        // R1: reset clears the sticky bit and results
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(flag_sat == 1'b0 && wb_data == 32'h0 && wb_en == 1'b0, "R1 reset after use",
              {31'd0, flag_sat}, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        summary();
    end
endmodule